// File: doc/BRIEF.md
# Paired-Access Register File

This block is a bank of thirty-two byte-wide working registers that serves an arithmetic datapath. It has two independent read ports and one write port. Each read port returns either a single register or an aligned pair of registers read as one 16-bit value. The write port stores either an 8-bit result into one register or a 16-bit result into an aligned pair. All of this happens in the same clock edge.

Three fixed pairs at the top of the bank are also driven continuously onto dedicated 16-bit pointer outputs, for use by the address generation logic. The highest of these pairs is the one meant for lookups into program storage. Reads are combinational. Writes take effect on the rising clock edge. A read in the same cycle as a write to the same register therefore returns the old contents.

Top module: `pairRegFile`

## Requirements
- R1: While reset (rstN low) is asserted, and after it is released, every register reads as zero until it is written.
- R2: With the wide select low, a read port returns the addressed register in bits 7:0 and zero in bits 15:8.
- R3: A write with wrEn high and wrWide low stores wrData[7:0] into the addressed register only; all other registers keep their values.
- R4: A write with wrEn high and wrWide high stores wrData[7:0] into the even register of the pair and wrData[15:8] into the odd register above it; bit 0 of wrAddr is ignored.
- R5: With the wide select high, a read port returns the odd register of the addressed pair in bits 15:8 and the even register in bits 7:0; bit 0 of the read address is ignored.
- R6: A written value appears at the read ports only from the cycle after the write edge; a read in the write cycle returns the previous contents.
- R7: ptrLow is {r27,r26}, ptrMid is {r29,r28}, and ptrTable is {r31,r30} (high byte first), and they follow writes on the next cycle.
- R8: The two read ports operate independently and may address the same register or pair at the same time.
- R9: With wrEn low, no register changes, whatever the values on the other write inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | 5 | Register index for read port A |
| rdWideA | input | 1 | Read port A returns a pair when high |
| rdAddrB | input | 5 | Register index for read port B |
| rdWideB | input | 1 | Read port B returns a pair when high |
| wrEn | input | 1 | Write enable |
| wrWide | input | 1 | Write writes a pair when high, a byte when low |
| wrAddr | input | 5 | Register index for the write |
| wrData | input | 16 | Write data; only the low byte is used for byte writes |
| rdDataA | output | 16 | Read port A data |
| rdDataB | output | 16 | Read port B data |
| ptrLow | output | 16 | Pointer pair from registers 26/27 |
| ptrMid | output | 16 | Pointer pair from registers 28/29 |
| ptrTable | output | 16 | Program-storage lookup pointer from registers 30/31 |

## Verification
The assertions assume that every input is at a known 0 or 1 at each rising edge while rstN is high. They place no limits on address alignment, so odd addresses with the wide select set are legal and must be handled by ignoring bit 0. The random stimulus drives fully defined values on every input in every cycle. It picks odd and even addresses freely and steers about half of the writes into the three pointer pairs, so that the pointer outputs change often.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int NUM_REGS = 32;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = $clog2(NUM_REGS);
  localparam int WIDE_W   = 2 * BYTE_W;
  localparam int NUM_PTRS = 3;
  localparam int PTR_BASE = NUM_REGS - 2 * NUM_PTRS;

  typedef struct packed {
    logic [NUM_REGS-1:0] byteWe;
    logic                wideSel;
    logic [BYTE_W-1:0]   loByte;
    logic [BYTE_W-1:0]   hiByte;
  } rfStrobes_t;
endpackage

// File: rtl/rfControl.sv
module rfControl
  import regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrWide,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDE_W-1:0] wrData,
  output rfStrobes_t        ctl
);
  logic [ADDR_W-1:0] evenIdx;
  logic [ADDR_W-1:0] oddIdx;

  assign evenIdx = {wrAddr[ADDR_W-1:1], 1'b0};
  assign oddIdx  = {wrAddr[ADDR_W-1:1], 1'b1};

  always_comb begin
    ctl         = '0;
    ctl.wideSel = wrWide;
    ctl.loByte  = wrData[BYTE_W-1:0];
    ctl.hiByte  = wrData[WIDE_W-1:BYTE_W];
    if (wrEn) begin
      if (wrWide) begin
        ctl.byteWe[evenIdx] = 1'b1;
        ctl.byteWe[oddIdx]  = 1'b1;
      end else begin
        ctl.byteWe[wrAddr]  = 1'b1;
      end
    end
  end

  // R9
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (ctl.byteWe == '0));
  // R3
  byte_one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrWide) |-> ($countones(ctl.byteWe) == 1));
  // R4
  wide_two_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrWide) |-> ($countones(ctl.byteWe) == 2));
endmodule

// File: rtl/rfDatapath.sv
module rfDatapath
  import regfile_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  rfStrobes_t                      ctl,
  input  logic [ADDR_W-1:0]               rdAddrA,
  input  logic                            rdWideA,
  input  logic [ADDR_W-1:0]               rdAddrB,
  input  logic                            rdWideB,
  output logic [WIDE_W-1:0]               rdDataA,
  output logic [WIDE_W-1:0]               rdDataB,
  output logic [NUM_PTRS-1:0][WIDE_W-1:0] ptrBus
);
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam bit IS_ODD = (k % 2) == 1;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regs[k] <= '0;
      else if (ctl.byteWe[k])
        regs[k] <= (IS_ODD && ctl.wideSel) ? ctl.hiByte : ctl.loByte;
    end
  end

  function automatic logic [WIDE_W-1:0] readSel(input logic [ADDR_W-1:0] a,
                                                 input logic w);
    if (w)
      return {regs[{a[ADDR_W-1:1], 1'b1}], regs[{a[ADDR_W-1:1], 1'b0}]};
    else
      return {{BYTE_W{1'b0}}, regs[a]};
  endfunction

  assign rdDataA = readSel(rdAddrA, rdWideA);
  assign rdDataB = readSel(rdAddrB, rdWideB);

  for (genvar p = 0; p < NUM_PTRS; p++) begin : g_ptr
    assign ptrBus[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
  end

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.byteWe == '0) |=> $stable(regs));
  // R7
  table_ptr_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.byteWe[PTR_BASE + 2*(NUM_PTRS-1)]
      |=> (ptrBus[NUM_PTRS-1][BYTE_W-1:0] == $past(ctl.loByte)));
  // R4
  table_ptr_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.byteWe[NUM_REGS-1] && ctl.wideSel)
      |=> (ptrBus[NUM_PTRS-1][WIDE_W-1:BYTE_W] == $past(ctl.hiByte)));
endmodule

// File: rtl/pairRegFile.sv
module pairRegFile
  import regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic              rdWideA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              rdWideB,
  input  logic              wrEn,
  input  logic              wrWide,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDE_W-1:0] wrData,
  output logic [WIDE_W-1:0] rdDataA,
  output logic [WIDE_W-1:0] rdDataB,
  output logic [WIDE_W-1:0] ptrLow,
  output logic [WIDE_W-1:0] ptrMid,
  output logic [WIDE_W-1:0] ptrTable
);
  rfStrobes_t ctl;
  logic [NUM_PTRS-1:0][WIDE_W-1:0] ptrBus;

  rfControl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWide(wrWide),
    .wrAddr(wrAddr), .wrData(wrData), .ctl(ctl)
  );

  rfDatapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .rdAddrA(rdAddrA), .rdWideA(rdWideA),
    .rdAddrB(rdAddrB), .rdWideB(rdWideB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .ptrBus(ptrBus)
  );

  assign ptrLow   = ptrBus[0];
  assign ptrMid   = ptrBus[1];
  assign ptrTable = ptrBus[NUM_PTRS-1];
endmodule

// File: tb/sim_pairRegFile.sv
module sim_pairRegFile;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic        rdWideA = 1'b0, rdWideB = 1'b0, wrEn = 1'b0, wrWide = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdDataA, rdDataB, ptrLow, ptrMid, ptrTable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [32];

  always #(CLK_P/2) clk = ~clk;

  pairRegFile u0 (
    .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdWideA(rdWideA),
    .rdAddrB(rdAddrB), .rdWideB(rdWideB), .wrEn(wrEn), .wrWide(wrWide),
    .wrAddr(wrAddr), .wrData(wrData), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .ptrLow(ptrLow), .ptrMid(ptrMid), .ptrTable(ptrTable)
  );

  function automatic logic [15:0] expRead(input logic [4:0] a, input logic w);
    if (w) return {model[{a[4:1], 1'b1}], model[{a[4:1], 1'b0}]};
    return {8'h00, model[a]};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string req);
    chk(rdWideA ? {req, " R5 portA"} : {req, " R2 portA"}, rdDataA, expRead(rdAddrA, rdWideA));
    chk(rdWideB ? {req, " R5 portB"} : {req, " R2 portB"}, rdDataB, expRead(rdAddrB, rdWideB));
    chk({req, " R7 ptrLow"},   ptrLow,   {model[27], model[26]});
    chk({req, " R7 ptrMid"},   ptrMid,   {model[29], model[28]});
    chk({req, " R7 ptrTable"}, ptrTable, {model[31], model[30]});
  endtask

  // one cycle: drive after negedge, check old contents, then update model at posedge
  task automatic step(input logic we, input logic ww, input logic [4:0] wa,
                      input logic [15:0] wd, input logic [4:0] ra, input logic rwa,
                      input logic [4:0] rb, input logic rwb, input string req);
    @(negedge clk);
    wrEn = we; wrWide = ww; wrAddr = wa; wrData = wd;
    rdAddrA = ra; rdWideA = rwa; rdAddrB = rb; rdWideB = rwb;
    #1;
    checkAll(req);
    @(posedge clk);
    if (we) begin
      if (ww) begin
        model[{wa[4:1], 1'b0}] = wd[7:0];
        model[{wa[4:1], 1'b1}] = wd[15:8];
      end else begin
        model[wa] = wd[7:0];
      end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    #(CLK_P * 2 + 1);
    // R1: outputs zero during reset
    checkAll("R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
    // R1: every register reads zero after reset
    for (int i = 0; i < 32; i += 2) step(1'b0, 1'b0, 5'd0, 16'h0, 5'(i), 1'b0, 5'(i+1), 1'b0, "R1");

    // R3: byte write leaves neighbour alone
    step(1'b1, 1'b0, 5'd4, 16'hAB5A, 5'd4, 1'b0, 5'd5, 1'b0, "R3 R6");
    step(1'b0, 1'b0, 5'd0, 16'h0, 5'd4, 1'b1, 5'd5, 1'b0, "R3");
    chk("R3 hi byte untouched", rdDataA, 16'h005A);
    // R4: wide write at odd address ignores bit 0
    step(1'b1, 1'b1, 5'd31, 16'hC3D4, 5'd30, 1'b1, 5'd31, 1'b0, "R4 R6");
    step(1'b0, 1'b0, 5'd0, 16'h0, 5'd31, 1'b1, 5'd30, 1'b0, "R4");
    chk("R4 R7 table pointer", ptrTable, 16'hC3D4);
    chk("R5 odd address pair", rdDataA, 16'hC3D4);
    // R6: same-cycle read returns old contents
    step(1'b1, 1'b0, 5'd30, 16'h0011, 5'd30, 1'b0, 5'd30, 1'b1, "R6 same cycle");
    chk("R6 old value", rdDataA, 16'h00D4);
    // R9: disabled write changes nothing
    step(1'b0, 1'b1, 5'd26, 16'hFFFF, 5'd26, 1'b1, 5'd26, 1'b0, "R9");
    step(1'b0, 1'b0, 5'd0, 16'h0, 5'd26, 1'b1, 5'd27, 1'b0, "R9 after");
    chk("R9 pair unchanged", rdDataA, 16'h0000);
    // R8: both ports on the same pair
    step(1'b1, 1'b1, 5'd28, 16'h1234, 5'd28, 1'b1, 5'd28, 1'b1, "R8");
    step(1'b0, 1'b0, 5'd0, 16'h0, 5'd29, 1'b1, 5'd28, 1'b1, "R8 both");
    chk("R8 port A equals port B", rdDataA, rdDataB);

    // random mix, half the writes aimed at pointer pairs
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] wa;
      wa = 5'($urandom);
      if ($urandom % 2 == 0) wa = 5'(26 + ($urandom % 6));
      step(($urandom % 4) != 0, 1'($urandom), wa, 16'($urandom),
           5'($urandom), 1'($urandom), 5'($urandom), 1'($urandom), "random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule